// File: doc/BRIEF.md
# Exhaustive fitness evaluator for a 4-bit arithmetic candidate

This controller grades a candidate arithmetic circuit that is physically present in the device. It reaches that circuit through a small strobe bus. On each pattern it writes an operand pair to the circuit, waits a programmable number of cycles for the logic to settle, and reads the 5-bit result back. It covers all 256 operand pairs of two 4-bit inputs. The golden result for each pair is computed inside the controller. Every result bit that matches the golden bit adds one point to the fitness score.

The maximum score is 1280 (256 patterns times 5 bits), and a circuit whose every output bit is wrong scores 0. So the score is a graded measure of closeness, which a search algorithm can climb, and not a pass/fail flag. A mode input picks the target function: the 5-bit sum of the operands, or their difference with a borrow bit on top. A start pulse begins an evaluation. The controller reports busy while it runs and then holds done, with the final score, until the next start.

Top module: `fitness_eval`

## Requirements
- R1: While reset is applied, and after it is released, busy, done, both bus strobes and the score are all 0.
- R2: A start seen while the block is idle or done is accepted. In the following cycle busy is 1, done is 0 and the score reads 0.
- R3: In one evaluation there are exactly 256 write strobes. Their write data runs 0x00, 0x01, ... 0xFF, with operand X in bits 7:4 and operand Y in bits 3:0. Each write is followed by exactly one read strobe, and no write and read strobe occur in the same cycle.
- R4: The read strobe comes settle+1 cycles after its write strobe. The settle value is sampled when start is accepted, and settle = 0 is allowed. Read data is taken in the cycle after the read strobe.
- R5: With mode = 0 the golden result is the 5-bit sum X+Y.
- R6: With mode = 1 the golden result is (X−Y) mod 32: bit 4 is the borrow (X<Y) and bits 3:0 are the low four bits of the difference.
- R7: The final score is the number of read-back bits that equal the golden bits, counted over all 256 patterns. It never exceeds 1280. A fully correct circuit scores 1280 and a fully inverted one scores 0.
- R8: done rises, and busy falls, exactly 256·(settle+3) clock edges after the edge that accepted start. While done is 1 and no new start comes, the score and done stay unchanged.
- R9: A start pulse while busy is 1 has no effect: neither the pattern sequence, the completion time nor the score changes.
- R10: mode and settle are sampled only when start is accepted. Changing them during an evaluation does not change its score or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an evaluation (accepted only when idle or done) |
| mode | input | 1 | Target function: 0 sum, 1 difference with borrow |
| settle | input | 4 | Cycles to wait between write and read of each pattern |
| bus_we | output | 1 | Write strobe toward the candidate circuit |
| bus_re | output | 1 | Read strobe toward the candidate circuit |
| bus_wdata | output | 8 | Operand pair {X, Y} being applied |
| bus_rdata | input | 5 | Result from the candidate, valid the cycle after bus_re |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | Evaluation finished, score valid |
| score | output | 11 | Count of correct result bits |

## Verification
The bench builds the block with its default parameters: two 4-bit operands, a 5-bit result and a 4-bit settle field. The full 256-pattern space therefore runs in a few thousand cycles, and the exact ceiling of 1280 is within reach. The bench's behavioural candidate can act as an adder, a subtracter, an adder with a bit stuck at zero, an inverted adder, or a slow adder that is wrong until four cycles after each write. Settle values 0 through 3 are used, which covers the zero-wait path, partial scores, the zero score and the effect of too short a settle time.

// File: rtl/fe_pkg.sv
package fe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WRITE  = 3'd1,
    ST_SETTLE = 3'd2,
    ST_READ   = 3'd3,
    ST_CAPT   = 3'd4,
    ST_DONE   = 3'd5
  } fe_state_e;

  localparam int MODE_ADD = 0;
  localparam int MODE_SUB = 1;
endpackage

// File: rtl/fe_golden.sv
module fe_golden #(
  parameter int XW = 4,
  parameter int YW = 4,
  parameter int RW = XW + 1
) (
  input  logic [XW+YW-1:0] pattern,
  input  logic             mode_sub,
  output logic [RW-1:0]    golden
);
  logic [RW-1:0] opx;
  logic [RW-1:0] opy;

  always_comb begin
    opx = RW'(pattern[XW+YW-1:YW]);
    opy = RW'(pattern[YW-1:0]);
    if (mode_sub) golden = opx - opy;
    else          golden = opx + opy;
  end
endmodule

// File: rtl/fe_bit_scorer.sv
module fe_bit_scorer #(
  parameter int RW = 5,
  parameter int CW = $clog2(RW + 1)
) (
  input  logic [RW-1:0] observed,
  input  logic [RW-1:0] golden,
  output logic [CW-1:0] hits
);
  logic [RW-1:0] match;

  genvar b;
  generate
    for (b = 0; b < RW; b++) begin : g_bit
      assign match[b] = ~(observed[b] ^ golden[b]);
    end
  endgenerate

  always_comb begin
    hits = '0;
    for (int i = 0; i < RW; i++) hits = hits + CW'(match[i]);
  end
endmodule

// File: rtl/fe_sequencer.sv
module fe_sequencer
  import fe_pkg::*;
#(
  parameter int PW       = 8,
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle,
  output logic                bus_we,
  output logic                bus_re,
  output logic [PW-1:0]       bus_wdata,
  output logic                busy,
  output logic                done,
  output logic                accept,
  output logic                capture
);
  localparam logic [PW-1:0] PAT_LAST = {PW{1'b1}};

  fe_state_e           state_q, state_d;
  logic [PW-1:0]       pat_q;
  logic [SETTLE_W-1:0] wait_q;
  logic [SETTLE_W-1:0] settle_q;

  assign accept  = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
  assign capture = (state_q == ST_CAPT);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_DONE: if (start) state_d = ST_WRITE;
      ST_WRITE:  state_d = (settle_q == '0) ? ST_READ : ST_SETTLE;
      ST_SETTLE: if (wait_q <= SETTLE_W'(1)) state_d = ST_READ;
      ST_READ:   state_d = ST_CAPT;
      ST_CAPT:   state_d = (pat_q == PAT_LAST) ? ST_DONE : ST_WRITE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      pat_q     <= '0;
      wait_q    <= '0;
      settle_q  <= '0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        pat_q    <= '0;
        settle_q <= settle;
      end else if (state_q == ST_CAPT && state_d == ST_WRITE) begin
        pat_q <= pat_q + PW'(1);
      end
      if (state_q == ST_WRITE)       wait_q <= settle_q;
      else if (state_q == ST_SETTLE) wait_q <= wait_q - SETTLE_W'(1);
      bus_we <= (state_d == ST_WRITE);
      bus_re <= (state_d == ST_READ);
      busy   <= (state_d != ST_IDLE) && (state_d != ST_DONE);
      done   <= (state_d == ST_DONE);
    end
  end

  assign bus_wdata = pat_q;

  // R3: write and read strobes never coincide
  p_we_re_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re));

  // R8: busy and done are never both set
  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R9: start during a pattern does not disturb the applied operands
  p_ignore_start_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !capture) |=> (bus_wdata == $past(bus_wdata)));

  // R3: a read strobe is never issued outside an evaluation
  p_read_in_run_r3: assert property (@(posedge clk) disable iff (rst)
    bus_re |-> busy);
endmodule

// File: rtl/fitness_eval.sv
module fitness_eval
  import fe_pkg::*;
#(
  parameter int XW       = 4,
  parameter int YW       = 4,
  parameter int SETTLE_W = 4,
  parameter int PW       = XW + YW,
  parameter int RW       = XW + 1,
  parameter int SCORE_W  = $clog2(RW * (1 << PW) + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                mode,
  input  logic [SETTLE_W-1:0] settle,
  output logic                bus_we,
  output logic                bus_re,
  output logic [PW-1:0]       bus_wdata,
  input  logic [RW-1:0]       bus_rdata,
  output logic                busy,
  output logic                done,
  output logic [SCORE_W-1:0]  score
);
  localparam int NPAT      = 1 << PW;
  localparam int MAX_SCORE = RW * NPAT;
  localparam int HW        = $clog2(RW + 1);

  logic          accept;
  logic          capture;
  logic          mode_q;
  logic [RW-1:0] golden;
  logic [HW-1:0] hits;
  logic [SCORE_W-1:0] score_q;

  fe_sequencer #(.PW(PW), .SETTLE_W(SETTLE_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .settle    (settle),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .done      (done),
    .accept    (accept),
    .capture   (capture)
  );

  fe_golden #(.XW(XW), .YW(YW), .RW(RW)) u_gold (
    .pattern  (bus_wdata),
    .mode_sub (mode_q),
    .golden   (golden)
  );

  fe_bit_scorer #(.RW(RW), .CW(HW)) u_score (
    .observed (bus_rdata),
    .golden   (golden),
    .hits     (hits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= 1'b0;
      score_q <= '0;
    end else if (accept) begin
      mode_q  <= mode;
      score_q <= '0;
    end else if (capture) begin
      score_q <= score_q + SCORE_W'(hits);
    end
  end

  assign score = score_q;

  // R7: score never exceeds the ceiling
  p_score_max_r7: assert property (@(posedge clk) disable iff (rst)
    score <= SCORE_W'(MAX_SCORE));

  // R8: result held while done and no new start
  p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(score)));

  // R2: accepted start clears the score and raises busy
  p_clear_on_start_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && score == '0 && !done));

  // R7: score only moves while an evaluation is running
  p_score_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(score));
endmodule

// File: tb/fitness_eval_test.sv
module fitness_eval_test;
  logic       clk = 0;
  logic       rst = 1;
  logic       start = 0;
  logic       mode = 0;
  logic [3:0] settle = 0;
  logic       bus_we, bus_re, busy, done;
  logic [7:0] bus_wdata;
  logic [4:0] bus_rdata = 0;
  logic [10:0] score;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  fitness_eval uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .settle(settle),
    .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .score(score)
  );

  // behavioural candidate circuit
  int   kind = 0;   // 0 add,1 sub,2 add bit4 stuck0,3 inverted add,4 slow add
  logic clr_stats = 0;
  logic [7:0] held_pat = 0;
  int   gap = 0;
  int   wr_cnt = 0, rd_cnt = 0, order_err = 0, gap_err = 0, last_gap = 0;
  int   exp_gap = 1;
  logic [8:0] next_pat = 0;

  function automatic logic [4:0] cut_out(int k, logic [7:0] p, int g);
    logic [4:0] s, d;
    s = 5'(p[7:4]) + 5'(p[3:0]);
    d = 5'(p[7:4]) - 5'(p[3:0]);
    case (k)
      1:       return d;
      2:       return s & 5'h0F;
      3:       return ~s;
      4:       return (g >= 4) ? s : ~s;
      default: return s;
    endcase
  endfunction

  function automatic int expect_score(int k, bit m, int g);
    int tot = 0;
    for (int p = 0; p < 256; p++) begin
      logic [4:0] gold, got;
      gold = m ? (5'(p[7:4]) - 5'(p[3:0])) : (5'(p[7:4]) + 5'(p[3:0]));
      got  = cut_out(k, 8'(p), g);
      tot += $countones(~(gold ^ got));
    end
    return tot;
  endfunction

  always @(posedge clk) begin
    if (clr_stats) begin
      wr_cnt <= 0; rd_cnt <= 0; order_err <= 0; gap_err <= 0; next_pat <= 0; gap <= 0;
    end else begin
      gap <= gap + 1;
      if (bus_we) begin
        held_pat <= bus_wdata;
        wr_cnt   <= wr_cnt + 1;
        gap      <= 0;
        if (9'(bus_wdata) != next_pat) order_err <= order_err + 1;
        next_pat <= next_pat + 1;
        if (bus_re) order_err <= order_err + 1;
      end
      if (bus_re) begin
        rd_cnt    <= rd_cnt + 1;
        last_gap  <= gap + 1;
        if (gap + 1 != exp_gap) gap_err <= gap_err + 1;
        bus_rdata <= cut_out(kind, held_pat, gap + 1);
      end
    end
  end

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // run one evaluation; poke=1 pulses start mid-run and disturbs mode/settle
  task automatic run_eval(string tag, bit m, int s, int k, bit poke);
    int n = 0;
    int exp_cycles = 256 * (s + 3) + 1;
    int exp_sc = expect_score(k, m, s + 1);
    logic [10:0] sc_hold;
    @(negedge clk);
    kind = k; mode = m; settle = 4'(s); exp_gap = s + 1;
    clr_stats = 1;
    @(negedge clk);
    clr_stats = 0;
    start = 1;
    @(posedge clk); n = 1;
    @(negedge clk);
    start = 0;
    check("R2", {tag, " busy after start"}, int'(busy), 1);
    check("R2", {tag, " score cleared"}, int'(score), 0);
    check("R2", {tag, " done cleared"}, int'(done), 0);
    while (!done && n < exp_cycles + 100) begin
      if (poke && n == 50) begin
        start = 1; mode = ~m; settle = 4'(s + 2);
      end else begin
        start = 0;
      end
      @(posedge clk); n++;
      @(negedge clk);
    end
    start = 0;
    check("R8", {tag, " completion edge"}, n, exp_cycles);
    check("R8", {tag, " busy dropped"}, int'(busy), 0);
    check("R7", {tag, " score"}, int'(score), exp_sc);
    check("R3", {tag, " writes"}, wr_cnt, 256);
    check("R3", {tag, " reads"}, rd_cnt, 256);
    check("R3", {tag, " order errors"}, order_err, 0);
    check("R4", {tag, " gap errors"}, gap_err, 0);
    sc_hold = score;
    repeat (5) @(negedge clk);
    check("R8", {tag, " score held"}, int'(score), int'(sc_hold));
    check("R8", {tag, " done held"}, int'(done), 1);
    mode = m; settle = 4'(s);
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", int'(busy), 0);
    check("R1", "done in reset", int'(done), 0);
    rst = 0;
    @(negedge clk);
    check("R1", "score after reset", int'(score), 0);
    check("R1", "strobes after reset", int'(bus_we) + int'(bus_re), 0);
  endtask

  task automatic t_add();   run_eval("R5 add exact s0",        0, 0, 0, 0); endtask
  task automatic t_sub();   run_eval("R6 sub exact s2",        1, 2, 1, 0); endtask
  task automatic t_wrong(); run_eval("R6 adder in sub mode",   1, 1, 0, 0); endtask
  task automatic t_stuck(); run_eval("R7 stuck carry",         0, 0, 2, 0); endtask
  task automatic t_inv();   run_eval("R7 inverted",            0, 0, 3, 0); endtask
  task automatic t_slow_ok();  run_eval("R4 slow settle3",     0, 3, 4, 0); endtask
  task automatic t_slow_bad(); run_eval("R4 slow settle1",     0, 1, 4, 0); endtask
  task automatic t_busy_start(); run_eval("R9 R10 start busy", 1, 1, 1, 1); endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_wrong();
    t_stuck();
    t_inv();
    t_slow_ok();
    t_slow_bad();
    t_busy_start();
    check("R7", "stuck carry ceiling value", expect_score(2, 0, 1), 1160);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule